// File: doc/BRIEF.md
# Paged Address Translator with Passthrough

This block turns a 16-bit CPU address into a 19-bit physical address covering 512K bytes. The CPU space is cut into sixteen 4K-byte pages. Each page owns a 12-bit map register, and the top four CPU address bits choose which register applies. The low twelve address bits pass through untouched as the offset. Seven bits of the selected register supply the upper physical bits. One more register bit is not used as an address bit. It is exported as a write-protect flag for the page being accessed.

The CPU loads and reads the map registers through a byte-wide register port while the active-low select is asserted. In that mode the four lowest address bits choose the register. When the select is idle, an active-low map-enable input picks between two cases. With it low, addresses go through the registers. With it high, the top address bits pass straight through, which gives an identity map. Passthrough is the state after reset. The byte lanes are wired to the register bits out of order. Software that wants an identity map for page N therefore writes N with its lowest bit rotated to the top.

Top module: `page_mapper`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all sixteen map registers to 0. After reset, with sel_n and xlate_n high, the block is in passthrough.
- R2: While sel_n=0 and rw=1, rd_data shows the 12-bit register chosen by cpu_addr[3:0] in the same cycle. In every other case rd_data is 0.
- R3: A register changes only at a rising clk edge where sel_n=0, rw=0 and wstb_n=0. Writes are refused when wstb_n=1, when rw=1, or when sel_n=1. Repeated reads do not change register contents.
- R4: Byte lane wiring on a write of wr_data into register bits: wr_data[3]→bit 8, wr_data[0]→bit 9, wr_data[1]→bit 10, wr_data[2]→bit 11, and wr_data[7:4]→bits 4:1. Bits 0, 5, 6 and 7 are always written 0.
- R5: Map mode (sel_n=1, xlate_n=0): cpu_addr[15:12] chooses a register, and all 12 of its bits appear on map_out.
- R6: Passthrough mode (sel_n=1, xlate_n=1): map_out[11:8]=cpu_addr[15:12] and map_out[7:0]=0.
- R7: While sel_n=0, map_out follows the passthrough rule of R6.
- R8: phys_addr = {map_out[3:1], map_out[11:8], cpu_addr[11:0]}. In passthrough this equals {3'b000, cpu_addr}.
- R9: prot equals map_out[4]. It is therefore 0 outside map mode.
- R10: Writing the byte {4'h0, N[0], N[3:1]} into register N for every page makes map-mode phys_addr equal {3'b000, cpu_addr}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Register-port select, active low |
| rw | input | 1 | Direction: 1 read, 0 write |
| wstb_n | input | 1 | Write strobe, active low |
| xlate_n | input | 1 | Map enable, active low |
| cpu_addr | input | 16 | CPU address |
| wr_data | input | 8 | CPU write byte |
| map_out | output | 12 | Map word (selected register or passthrough word) |
| phys_addr | output | 19 | Physical address |
| prot | output | 1 | Write-protect flag of the current page |
| rd_data | output | 12 | Register read port |

## Verification
Only register writes take a clock. A write presented in one cycle is visible on rd_data or map_out after the next rising edge. The bench drives the write on a falling edge, removes it on the following falling edge, and only then samples. Reads, map_out, phys_addr and prot are combinational in the current inputs. They are sampled 1 ns after the inputs change on a falling edge, well away from the next rising edge.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  localparam int PAGE_W   = 4;
  localparam int OFF_W    = 12;
  localparam int MAP_W    = 12;
  localparam int BYTE_W   = 8;
  localparam int HI_W     = 3;
  localparam int VA_W     = PAGE_W + OFF_W;
  localparam int PA_W     = OFF_W + PAGE_W + HI_W;
  localparam int NREG     = 1 << PAGE_W;
  localparam int PROT_BIT = 4;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_MAP    = 2'd1,
    MODE_ACCESS = 2'd2
  } mode_e;

  // byte lanes to register bits (scrambled low nibble, high nibble to bits 4:1)
  function automatic logic [MAP_W-1:0] lane_load(input logic [BYTE_W-1:0] b);
    logic [MAP_W-1:0] w;
    w      = '0;
    w[8]   = b[3];
    w[9]   = b[0];
    w[10]  = b[1];
    w[11]  = b[2];
    w[4:1] = b[7:4];
    return w;
  endfunction

  function automatic logic [MAP_W-1:0] pass_word(input logic [PAGE_W-1:0] page);
    logic [MAP_W-1:0] w;
    w = '0;
    w[MAP_W-1 -: PAGE_W] = page;
    return w;
  endfunction

  function automatic logic [PA_W-1:0] make_phys(input logic [MAP_W-1:0] m,
                                                input logic [OFF_W-1:0] off);
    return {m[HI_W:1], m[MAP_W-1 -: PAGE_W], off};
  endfunction

  function automatic mode_e mode_of(input logic sel_n, input logic xlate_n);
    if (!sel_n)       return MODE_ACCESS;
    else if (!xlate_n) return MODE_MAP;
    else              return MODE_PASS;
  endfunction
endpackage

// File: rtl/pmm_decode.sv
module pmm_decode
  import pmm_pkg::*;
(
  input  logic  sel_n,
  input  logic  rw,
  input  logic  wstb_n,
  input  logic  xlate_n,
  output mode_e mode,
  output logic  wr_fire,
  output logic  rd_fire
);
  always_comb begin
    mode    = mode_of(sel_n, xlate_n);
    wr_fire = (mode == MODE_ACCESS) && !rw && !wstb_n;
    rd_fire = (mode == MODE_ACCESS) && rw;
  end
endmodule

// File: rtl/pmm_regfile.sv
module pmm_regfile #(
  parameter int NREG  = 16,
  parameter int MAP_W = 12,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [MAP_W-1:0] wr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [MAP_W-1:0] rd_word,
  input  logic [IDX_W-1:0] map_idx,
  output logic [MAP_W-1:0] map_word
);
  logic [MAP_W-1:0] regs [NREG];
  logic [NREG-1:0]  hit;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (hit[i]) regs[i] <= wr_word;
    end
  end

  assign rd_word  = regs[rd_idx];
  assign map_word = regs[map_idx];
endmodule

// File: rtl/pmm_xlate.sv
module pmm_xlate
  import pmm_pkg::*;
(
  input  mode_e             mode,
  input  logic [PAGE_W-1:0] page,
  input  logic [MAP_W-1:0]  reg_word,
  input  logic [OFF_W-1:0]  offset,
  output logic [MAP_W-1:0]  map_out,
  output logic [PA_W-1:0]   phys_addr,
  output logic              prot
);
  always_comb begin
    map_out   = (mode == MODE_MAP) ? reg_word : pass_word(page);
    phys_addr = make_phys(map_out, offset);
    prot      = map_out[PROT_BIT];
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import pmm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n,
  input  logic                rw,
  input  logic                wstb_n,
  input  logic                xlate_n,
  input  logic [VA_W-1:0]     cpu_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic [MAP_W-1:0]    map_out,
  output logic [PA_W-1:0]     phys_addr,
  output logic                prot,
  output logic [MAP_W-1:0]    rd_data
);
  mode_e            mode;
  logic             wr_fire;
  logic             rd_fire;
  logic [MAP_W-1:0] rd_word;
  logic [MAP_W-1:0] map_word;
  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] reg_sel;

  assign page    = cpu_addr[VA_W-1 -: PAGE_W];
  assign reg_sel = cpu_addr[PAGE_W-1:0];

  pmm_decode u_dec (
    .sel_n(sel_n), .rw(rw), .wstb_n(wstb_n), .xlate_n(xlate_n),
    .mode(mode), .wr_fire(wr_fire), .rd_fire(rd_fire)
  );

  pmm_regfile #(.NREG(NREG), .MAP_W(MAP_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire), .wr_idx(reg_sel), .wr_word(lane_load(wr_data)),
    .rd_idx(reg_sel), .rd_word(rd_word),
    .map_idx(page), .map_word(map_word)
  );

  pmm_xlate u_xl (
    .mode(mode), .page(page), .reg_word(map_word),
    .offset(cpu_addr[OFF_W-1:0]),
    .map_out(map_out), .phys_addr(phys_addr), .prot(prot)
  );

  assign rd_data = rd_fire ? rd_word : '0;
endmodule

// File: rtl/pmm_chk.sv
module pmm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel_n,
  input logic        rw,
  input logic        xlate_n,
  input logic [15:0] cpu_addr,
  input logic [11:0] map_out,
  input logic [18:0] phys_addr,
  input logic        prot,
  input logic [11:0] rd_data
);
  // R6
  pass_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && xlate_n) |-> (map_out == {cpu_addr[15:12], 8'h00}));

  // R7
  access_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> (map_out == {cpu_addr[15:12], 8'h00}));

  // R8
  pass_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && xlate_n) |-> (phys_addr == {3'b000, cpu_addr}));

  // R9
  prot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n || xlate_n) |-> !prot);

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_n && rw) |-> (rd_data == 12'h000));

  // R3
  rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && rw && $past(!sel_n && rw) && $stable(cpu_addr[3:0])) |-> $stable(rd_data));

  // R5
  map_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && !xlate_n && $past(sel_n) && $stable(cpu_addr[15:12])) |-> $stable(map_out));
endmodule

bind page_mapper pmm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rw(rw), .xlate_n(xlate_n),
  .cpu_addr(cpu_addr), .map_out(map_out), .phys_addr(phys_addr),
  .prot(prot), .rd_data(rd_data)
);

// File: tb/sim_page_mapper.sv
module sim_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        rw = 1'b1;
  logic        wstb_n = 1'b1;
  logic        xlate_n = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  wr_data = 8'h00;
  logic [11:0] map_out;
  logic [18:0] phys_addr;
  logic        prot;
  logic [11:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  page_mapper u0 (.*);

  // {page, byte written, expected 12-bit register}
  localparam logic [23:0] TBL [16] = '{
    {4'h0, 8'h00, 12'h000}, {4'h1, 8'h18, 12'h102},
    {4'h2, 8'h21, 12'h204}, {4'h3, 8'h39, 12'h306},
    {4'h4, 8'h42, 12'h408}, {4'h5, 8'h5A, 12'h50A},
    {4'h6, 8'h63, 12'h60C}, {4'h7, 8'h7B, 12'h70E},
    {4'h8, 8'h84, 12'h810}, {4'h9, 8'h9C, 12'h912},
    {4'hA, 8'hA5, 12'hA14}, {4'hB, 8'hBD, 12'hB16},
    {4'hC, 8'hC6, 12'hC18}, {4'hD, 8'hDE, 12'hD1A},
    {4'hE, 8'hE7, 12'hE1C}, {4'hF, 8'hFF, 12'hF1E}
  };
  // single-bit byte n -> expected register word
  localparam logic [11:0] LANE [8] = '{
    12'h200, 12'h400, 12'h800, 12'h100, 12'h002, 12'h004, 12'h008, 12'h010
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] r, input logic [7:0] b,
                    input logic s_n, input logic rwv, input logic st_n);
    @(negedge clk);
    sel_n = s_n; rw = rwv; wstb_n = st_n;
    cpu_addr = {12'hFE4, r}; wr_data = b;
    @(negedge clk);
    sel_n = 1'b1; rw = 1'b1; wstb_n = 1'b1;
  endtask

  task automatic rdchk(input string req, input logic [3:0] r, input logic [11:0] exp);
    @(negedge clk);
    sel_n = 1'b0; rw = 1'b1; wstb_n = 1'b1; cpu_addr = {12'hFE4, r};
    #1 chk(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic look(input logic [15:0] a, input logic xl);
    @(negedge clk);
    sel_n = 1'b1; rw = 1'b1; wstb_n = 1'b1; xlate_n = xl; cpu_addr = a;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1, R6, R8: passthrough after reset
    look(16'h5123, 1'b1);
    chk("R1/R6 map_out", 32'(map_out), 32'h500);
    chk("R8 phys pass", 32'(phys_addr), 32'h05123);
    chk("R9 prot pass", 32'(prot), 32'h0);
    look(16'h9ABC, 1'b0);
    chk("R1 cleared reg", 32'(map_out), 32'h000);
    chk("R1 phys", 32'(phys_addr), 32'h00ABC);

    // R3, R4, R2: table of writes with read-back
    for (int i = 0; i < 16; i++) begin
      wr(TBL[i][23:20], TBL[i][19:12], 1'b0, 1'b0, 1'b0);
      rdchk("R2/R4 readback", TBL[i][23:20], TBL[i][11:0]);
    end
    // R5, R8, R9: map mode over the same table
    for (int i = 0; i < 16; i++) begin
      logic [11:0] e;
      e = TBL[i][11:0];
      look({TBL[i][23:20], 12'h3C7}, 1'b0);
      chk("R5 map word", 32'(map_out), 32'(e));
      chk("R8 phys map", 32'(phys_addr), 32'({e[3:1], e[11:8], 12'h3C7}));
      chk("R9 prot map", 32'(prot), 32'(e[4]));
    end

    // R3: refused writes
    wr(4'h2, 8'hFF, 1'b0, 1'b0, 1'b1);
    rdchk("R3 strobe high", 4'h2, 12'h204);
    wr(4'h2, 8'hFF, 1'b0, 1'b1, 1'b0);
    rdchk("R3 rw high", 4'h2, 12'h204);
    wr(4'h2, 8'hFF, 1'b1, 1'b0, 1'b0);
    rdchk("R3 select idle", 4'h2, 12'h204);
    rdchk("R3 repeat read", 4'h2, 12'h204);

    // R4: one lane at a time
    for (int n = 0; n < 8; n++) begin
      wr(4'h5, 8'(1 << n), 1'b0, 1'b0, 1'b0);
      rdchk("R4 lane", 4'h5, LANE[n]);
    end
    look(16'h5800, 1'b0);
    chk("R9 protect page", 32'(prot), 32'h1);
    chk("R8 protect phys", 32'(phys_addr), 32'h00800);

    // R2: read port idle cases
    @(negedge clk);
    sel_n = 1'b0; rw = 1'b0; wstb_n = 1'b1; cpu_addr = 16'hFE43;
    #1 chk("R2 idle rw low", 32'(rd_data), 32'h0);
    chk("R7 access word", 32'(map_out), 32'hF00);
    look(16'h3003, 1'b0);
    chk("R2 idle select", 32'(rd_data), 32'h0);

    // R10: identity map through rotated values
    for (int p = 0; p < 16; p++) begin
      logic [3:0] q;
      q = 4'(p);
      wr(q, {4'h0, q[0], q[3:1]}, 1'b0, 1'b0, 1'b0);
    end
    for (int p = 0; p < 16; p++) begin
      look({4'(p), 12'h7A5}, 1'b0);
      chk("R10 identity", 32'(phys_addr), 32'({3'b000, 4'(p), 12'h7A5}));
    end

    // R1: reset in mid-run clears the registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look(16'hD123, 1'b0);
    chk("R1 reset clears", 32'(map_out), 32'h000);
    rdchk("R1 reset readback", 4'hD, 12'h000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule